// File: doc/BRIEF.md
# Two-Plane Flash Page-Buffer Write Controller

This block models the write path of a small on-chip flash with two independent planes. One is the main array and the other is a separate data plane that can be read while a command runs. Software stages one page of data through a buffer of 32-bit bus writes. The buffer is organised as 64-bit double-words, and each double-word only commits when both of its halves have arrived. Software then issues a command that either erases a row or programs a page in the plane that the command code selects.

Programming behaves like real flash. It can only clear bits, so the new contents are the old contents ANDed with the buffer. Erasing sets a whole row back to ones. While a command runs, the controller holds a busy state for a fixed number of cycles and rejects any command that arrives. It also counts page writes that go beyond the permitted number of programs per row since that row's last erase. The storage arrays are small register memories, and either plane can be read a 32-bit word at a time.

Top module: `flash_pgbuf_ctrl`

## Requirements
- R1: After reset `ready` is 1, `cmd_err` is 0, `overprog_count` is 0, and every word of both planes reads as all ones.
- R2: The buffer holds 16 words indexed by `wr_idx`. A write to an even index is held as a pending lower half. A write to an odd index commits the pair (index-1, index) only when the pending lower half belongs to that same pair; otherwise the odd write is dropped. A newer even write replaces the pending half. Buffer writes while `ready` is 0 are ignored.
- R3: A page write sets each of the 16 words of the addressed page to its old value ANDed with the corresponding buffer word.
- R4: A row erase sets all 64 words of the addressed row to all ones and leaves every other row of both planes unchanged.
- R5: Bit 2 of `cmd_code` selects the plane (0 main, 1 data). Bits 1:0 select the operation: 01 is row erase and 10 is page write. Codes with bits 1:0 equal to 00 or 11 are rejected. `cmd_err` is a one-cycle pulse in the cycle after a rejected command and is 0 otherwise.
- R6: `cmd_addr` is a halfword offset within the selected plane. The row is addr/128 and the page within that row is (addr/32) mod 4. The lower five bits do not change the target.
- R7: An accepted command drives `ready` low for exactly BUSY_CYCLES cycles, starting in the next cycle. Storage changes at the edge where `ready` returns high.
- R8: A command presented while `ready` is 0 is rejected with `cmd_err` and has no effect on storage.
- R9: A command whose row is not below the selected plane's row count (MAIN_ROWS or DATA_ROWS) is rejected with `cmd_err` and changes no storage.
- R10: After a page write completes, every buffer word is all ones and any pending lower half is discarded.
- R11: A page write to a row that already holds 8 or more programs since its last erase (or since reset) increments `overprog_count`, which saturates at 255. The write itself still takes place.
- R12: When `rd_en` is high, `rd_plane` and `rd_idx` (a 32-bit word index within the plane) are sampled, and `rd_data` shows that word in the next cycle. An index beyond the data plane returns 0. Reads are served while a command is busy and return the contents from before the command takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_idx | input | 4 | Word index within the page buffer |
| wr_data | input | 32 | Buffer write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Plane select (bit 2) and operation (bits 1:0) |
| cmd_addr | input | 16 | Halfword offset within the selected plane |
| rd_en | input | 1 | Read strobe |
| rd_plane | input | 1 | Read plane select (0 main, 1 data) |
| rd_idx | input | 8 | 32-bit word index within the plane |
| ready | output | 1 | High when no command is running |
| cmd_err | output | 1 | Rejected-command pulse |
| rd_data | output | 32 | Registered read data |
| overprog_count | output | 8 | Saturating count of page writes beyond the per-row limit |

## Verification
The bench targets the half-word pairing rules. A design that commits lower halves on their own, or that accepts an upper half from a different pair, would leave zeros in pages that should have stayed erased. It also issues commands during the busy window and with rows just past each plane's end. A design that latched those commands would corrupt rows that the whole-plane sweeps find. Halfword offsets with junk in the low bits, and a write issued right after another write without a refill, catch designs that treat the address as a byte or word offset or that keep stale buffer contents. The ninth and tenth programs to one row, followed by an erase, check that the over-program count neither fires early nor survives the erase.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  localparam int PAGE_WORDS    = 16;
  localparam int PAGES_PER_ROW = 4;
  localparam int ROW_WORDS     = PAGE_WORDS * PAGES_PER_ROW;
  localparam int BUF_DWORDS    = PAGE_WORDS / 2;
  localparam int HW_PER_PAGE   = PAGE_WORDS * 2;
  localparam int HW_PER_ROW    = HW_PER_PAGE * PAGES_PER_ROW;
  localparam int PROG_LIMIT    = 8;
  localparam int PG_W          = $clog2(PAGES_PER_ROW);
  localparam int IDX_W         = $clog2(PAGE_WORDS);
  localparam int SLOT_W        = $clog2(BUF_DWORDS);
  localparam int PAGE_BITS     = PAGE_WORDS * 32;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_ERASE = 2'b01,
    OP_WRITE = 2'b10
  } op_e;

  typedef struct packed {
    logic valid;
    logic plane;
    op_e  op;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [2:0] code);
    cmd_dec_t d;
    d.plane = code[2];
    case (code[1:0])
      2'b01:   d.op = OP_ERASE;
      2'b10:   d.op = OP_WRITE;
      default: d.op = OP_NONE;
    endcase
    d.valid = (d.op != OP_NONE);
    return d;
  endfunction

  // halfword offset -> row number within the plane
  function automatic logic [15:0] hw_row(input logic [15:0] a);
    return a >> $clog2(HW_PER_ROW);
  endfunction

  // halfword offset -> page number within its row
  function automatic logic [PG_W-1:0] hw_page(input logic [15:0] a);
    return PG_W'(a >> $clog2(HW_PER_PAGE));
  endfunction

  // flash programming can only clear bits
  function automatic logic [31:0] program_word(input logic [31:0] old_w,
                                               input logic [31:0] new_w);
    return old_w & new_w;
  endfunction
endpackage

// File: rtl/fpb_page_buffer.sv
module fpb_page_buffer
  import fpb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [31:0]          wr_data,
  input  logic                 clear,
  output logic [PAGE_BITS-1:0] page_flat,
  output logic                 commit_evt
);
  logic [63:0]       dw [BUF_DWORDS];
  logic              pend_v;
  logic [SLOT_W-1:0] pend_slot;
  logic [31:0]       pend_lo;
  logic [SLOT_W-1:0] slot;

  assign slot       = wr_idx[IDX_W-1:1];
  assign commit_evt = wr_en & wr_idx[0] & pend_v & (pend_slot == slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_DWORDS; i++) dw[i] <= '1;
      pend_v    <= 1'b0;
      pend_slot <= '0;
      pend_lo   <= '0;
    end else if (clear) begin
      for (int i = 0; i < BUF_DWORDS; i++) dw[i] <= '1;
      pend_v <= 1'b0;
    end else if (wr_en) begin
      if (!wr_idx[0]) begin
        pend_v    <= 1'b1;
        pend_slot <= slot;
        pend_lo   <= wr_data;
      end else if (commit_evt) begin
        dw[slot] <= {wr_data, pend_lo};
        pend_v   <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < BUF_DWORDS; g++) begin : g_flat
    assign page_flat[g*64 +: 64] = dw[g];
  end
endmodule

// File: rtl/fpb_plane.sv
module fpb_plane
  import fpb_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int RD_W = 8,
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int WORDS = ROWS * ROW_WORDS,
  localparam int AW    = $clog2(WORDS)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 erase_go,
  input  logic                 prog_go,
  input  logic [RW-1:0]        row_sel,
  input  logic [PG_W-1:0]      page_sel,
  input  logic [PAGE_BITS-1:0] page_data,
  input  logic [RD_W-1:0]      rd_idx,
  output logic [31:0]          rd_word,
  output logic                 overprog_hit
);
  logic [31:0] mem  [WORDS];
  logic [3:0]  pcnt [ROWS];
  logic [AW-1:0] row_base, page_base;

  assign row_base  = AW'(row_sel) << $clog2(ROW_WORDS);
  assign page_base = row_base + (AW'(page_sel) << $clog2(PAGE_WORDS));
  assign overprog_hit = prog_go && (pcnt[row_sel] >= 4'(PROG_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (erase_go) begin
      for (int k = 0; k < ROW_WORDS; k++) mem[row_base + AW'(k)] <= '1;
    end else if (prog_go) begin
      for (int k = 0; k < PAGE_WORDS; k++)
        mem[page_base + AW'(k)] <= program_word(mem[page_base + AW'(k)],
                                                page_data[k*32 +: 32]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) pcnt[r] <= '0;
    end else if (erase_go) begin
      pcnt[row_sel] <= '0;
    end else if (prog_go && pcnt[row_sel] != 4'hF) begin
      pcnt[row_sel] <= pcnt[row_sel] + 4'd1;
    end
  end

  assign rd_word = ({1'b0, rd_idx} < (RD_W+1)'(WORDS)) ? mem[rd_idx[AW-1:0]] : '0;
endmodule

// File: rtl/fpb_cmd_seq.sv
module fpb_cmd_seq
  import fpb_pkg::*;
#(
  parameter int MAIN_ROWS   = 4,
  parameter int DATA_ROWS   = 2,
  parameter int BUSY_CYCLES = 4,
  localparam int MAXR = (MAIN_ROWS > DATA_ROWS) ? MAIN_ROWS : DATA_ROWS,
  localparam int RWM  = (MAXR > 1) ? $clog2(MAXR) : 1,
  localparam int CW   = $clog2(BUSY_CYCLES + 1)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_code,
  input  logic [15:0]     cmd_addr,
  output logic            ready,
  output logic            cmd_err,
  output logic            cmd_accept,
  output logic            cmd_reject,
  output logic            op_done,
  output logic            op_plane,
  output op_e             op_kind,
  output logic [RWM-1:0]  op_row,
  output logic [PG_W-1:0] op_page
);
  cmd_dec_t      dec;
  logic [15:0]   row;
  logic          in_range;
  logic          busy;
  logic [CW-1:0] cnt;

  assign dec      = decode_cmd(cmd_code);
  assign row      = hw_row(cmd_addr);
  assign in_range = dec.plane ? (row < 16'(DATA_ROWS)) : (row < 16'(MAIN_ROWS));

  assign ready      = ~busy;
  assign cmd_accept = cmd_valid & ready & dec.valid & in_range;
  assign cmd_reject = cmd_valid & ~cmd_accept;
  assign op_done    = busy & (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      cmd_err  <= 1'b0;
      op_plane <= 1'b0;
      op_kind  <= OP_NONE;
      op_row   <= '0;
      op_page  <= '0;
    end else begin
      cmd_err <= cmd_reject;
      if (cmd_accept) begin
        busy     <= 1'b1;
        cnt      <= CW'(BUSY_CYCLES);
        op_plane <= dec.plane;
        op_kind  <= dec.op;
        op_row   <= RWM'(row);
        op_page  <= hw_page(cmd_addr);
      end else if (busy) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_pgbuf_ctrl.sv
module flash_pgbuf_ctrl
  import fpb_pkg::*;
#(
  parameter int MAIN_ROWS   = 4,
  parameter int DATA_ROWS   = 2,
  parameter int BUSY_CYCLES = 4,
  parameter int OVW         = 8,
  localparam int MAXR = (MAIN_ROWS > DATA_ROWS) ? MAIN_ROWS : DATA_ROWS,
  localparam int RWM  = (MAXR > 1) ? $clog2(MAXR) : 1,
  localparam int RD_W = $clog2(MAXR * ROW_WORDS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic [15:0]      cmd_addr,
  input  logic             rd_en,
  input  logic             rd_plane,
  input  logic [RD_W-1:0]  rd_idx,
  output logic             ready,
  output logic             cmd_err,
  output logic [31:0]      rd_data,
  output logic [OVW-1:0]   overprog_count
);
  // named internal events
  logic                 cmd_accept, cmd_reject, op_done, buf_commit;
  logic                 op_plane;
  op_e                  op_kind;
  logic [RWM-1:0]       op_row;
  logic [PG_W-1:0]      op_page;
  logic [PAGE_BITS-1:0] page_flat;
  logic                 buf_clear;
  logic [31:0]          plane_word [2];
  logic [1:0]           plane_hit;
  logic                 any_overprog;

  fpb_cmd_seq #(
    .MAIN_ROWS(MAIN_ROWS), .DATA_ROWS(DATA_ROWS), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .ready(ready), .cmd_err(cmd_err),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject), .op_done(op_done),
    .op_plane(op_plane), .op_kind(op_kind), .op_row(op_row), .op_page(op_page)
  );

  assign buf_clear = op_done & (op_kind == OP_WRITE);

  fpb_page_buffer u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en & ready), .wr_idx(wr_idx), .wr_data(wr_data),
    .clear(buf_clear), .page_flat(page_flat), .commit_evt(buf_commit)
  );

  for (genvar g = 0; g < 2; g++) begin : g_plane
    localparam int ROWS_G = (g == 0) ? MAIN_ROWS : DATA_ROWS;
    localparam int RW_G   = (ROWS_G > 1) ? $clog2(ROWS_G) : 1;
    logic sel;
    assign sel = op_done & (op_plane == 1'(g));
    fpb_plane #(.ROWS(ROWS_G), .RD_W(RD_W)) u_plane (
      .clk(clk), .rst_n(rst_n),
      .erase_go(sel & (op_kind == OP_ERASE)),
      .prog_go(sel & (op_kind == OP_WRITE)),
      .row_sel(op_row[RW_G-1:0]), .page_sel(op_page),
      .page_data(page_flat), .rd_idx(rd_idx),
      .rd_word(plane_word[g]), .overprog_hit(plane_hit[g])
    );
  end

  assign any_overprog = |plane_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data        <= '0;
      overprog_count <= '0;
    end else begin
      if (rd_en) rd_data <= rd_plane ? plane_word[1] : plane_word[0];
      if (any_overprog && overprog_count != '1)
        overprog_count <= overprog_count + OVW'(1);
    end
  end
endmodule

// File: rtl/fpb_checker.sv
module fpb_checker #(
  parameter int BUSY_CYCLES = 4,
  parameter int OVW         = 8
)(
  input logic           clk,
  input logic           rst_n,
  input logic           ready,
  input logic           cmd_valid,
  input logic           cmd_err,
  input logic           cmd_accept,
  input logic           cmd_reject,
  input logic           op_done,
  input logic [OVW-1:0] overprog_count
);
  int blen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          blen <= 0;
    else if (cmd_accept) blen <= 1;
    else if (!ready)     blen <= blen + 1;
  end

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> !ready);
  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> (blen == BUSY_CYCLES));
  // R7
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> ready);
  // R8
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ready) |=> cmd_err);
  // R9
  reject_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> cmd_err);
  // R5
  idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !cmd_err);
  // R11
  ov_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (overprog_count >= $past(overprog_count)));
endmodule

bind flash_pgbuf_ctrl fpb_checker #(.BUSY_CYCLES(BUSY_CYCLES), .OVW(OVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .cmd_valid(cmd_valid),
  .cmd_err(cmd_err), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
  .op_done(op_done), .overprog_count(overprog_count)
);

// File: tb/tb_flash_pgbuf_ctrl.sv
module tb_flash_pgbuf_ctrl;
  localparam int MROWS = 4;
  localparam int DROWS = 2;
  localparam int BUSY  = 4;
  localparam int MW    = MROWS * 64;
  localparam int DW    = DROWS * 64;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic        cmd_valid = 0;
  logic [2:0]  cmd_code = 0;
  logic [15:0] cmd_addr = 0;
  logic        rd_en = 0;
  logic        rd_plane = 0;
  logic [7:0]  rd_idx = 0;
  logic        ready, cmd_err;
  logic [31:0] rd_data;
  logic [7:0]  overprog_count;

  flash_pgbuf_ctrl #(.MAIN_ROWS(MROWS), .DATA_ROWS(DROWS), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .rd_en(rd_en), .rd_plane(rd_plane), .rd_idx(rd_idx),
    .ready(ready), .cmd_err(cmd_err), .rd_data(rd_data),
    .overprog_count(overprog_count)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  logic [31:0] exp_m [MW];
  logic [31:0] exp_d [DW];
  logic [31:0] mbuf [16];
  bit          mpv;
  int          mps;
  logic [31:0] mpd;
  int          rc_m [MROWS];
  int          rc_d [DROWS];
  int          exp_ov = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int s, input int k);
    return (32'(s) * 32'h9E3779B1) ^ (32'(k) << 3) ^ 32'hA5A50F0F;
  endfunction

  task automatic bus_wr(input int idx, input logic [31:0] d, input bit model);
    wr_en = 1; wr_idx = 4'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (model) begin
      if (idx % 2 == 0) begin
        mpv = 1; mps = idx / 2; mpd = d;
      end else if (mpv && mps == idx / 2) begin
        mbuf[idx-1] = mpd; mbuf[idx] = d; mpv = 0;
      end
    end
  endtask

  task automatic fill_page(input int seed);
    for (int k = 0; k < 16; k++) bus_wr(k, pat(seed, k), 1);
  endtask

  task automatic rd(input bit pl, input int idx, output logic [31:0] v);
    rd_en = 1; rd_plane = pl; rd_idx = 8'(idx);
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic verify_all(input string req);
    logic [31:0] v;
    for (int i = 0; i < MW; i++) begin
      rd(0, i, v); check(v === exp_m[i], req, v, exp_m[i]);
    end
    for (int i = 0; i < DW; i++) begin
      rd(1, i, v); check(v === exp_d[i], req, v, exp_d[i]);
    end
  endtask

  task automatic model_apply(input bit pl, input int op, input int row, input int pg);
    if (op == 1) begin
      for (int k = 0; k < 64; k++)
        if (pl) exp_d[row*64+k] = '1; else exp_m[row*64+k] = '1;
      if (pl) rc_d[row] = 0; else rc_m[row] = 0;
    end else begin
      int c;
      c = pl ? rc_d[row] : rc_m[row];
      if (c >= 8 && exp_ov < 255) exp_ov++;
      if (c < 15) c++;
      if (pl) rc_d[row] = c; else rc_m[row] = c;
      for (int k = 0; k < 16; k++) begin
        int a;
        a = row*64 + pg*16 + k;
        if (pl) exp_d[a] = exp_d[a] & mbuf[k]; else exp_m[a] = exp_m[a] & mbuf[k];
      end
      for (int k = 0; k < 16; k++) mbuf[k] = '1;
      mpv = 0;
    end
  endtask

  task automatic do_cmd(input logic [2:0] code, input int addr, input string req);
    bit pl; int op, row, pg, rows; bit bad;
    pl = code[2]; op = int'(code[1:0]); row = addr / 128; pg = (addr / 32) % 4;
    rows = pl ? DROWS : MROWS;
    bad = !((op == 1) || (op == 2)) || (row >= rows);
    cmd_valid = 1; cmd_code = code; cmd_addr = 16'(addr);
    @(negedge clk);
    cmd_valid = 0;
    check(cmd_err == bad, req, 32'(cmd_err), 32'(bad));
    if (bad) begin
      check(ready == 1, "R9 ready stays high on reject", 32'(ready), 1);
      @(negedge clk);
      check(cmd_err == 0, "R5 err is one pulse", 32'(cmd_err), 0);
    end else begin
      check(ready == 0, "R7 busy cycle", 32'(ready), 0);
      for (int c = 1; c < BUSY; c++) begin
        @(negedge clk);
        check(ready == 0, "R7 busy cycle", 32'(ready), 0);
      end
      @(negedge clk);
      check(ready == 1, "R7 ready returns", 32'(ready), 1);
      model_apply(pl, op, row, pg);
      check(overprog_count == 8'(exp_ov), "R11 overprog count", 32'(overprog_count),
            32'(exp_ov));
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < MW; i++) exp_m[i] = '1;
    for (int i = 0; i < DW; i++) exp_d[i] = '1;
    for (int k = 0; k < 16; k++) mbuf[k] = '1;
    for (int r = 0; r < MROWS; r++) rc_m[r] = 0;
    for (int r = 0; r < DROWS; r++) rc_d[r] = 0;
    mpv = 0; mps = 0; mpd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(ready == 1, "R1 ready", 32'(ready), 1);
    check(cmd_err == 0, "R1 cmd_err", 32'(cmd_err), 0);
    check(overprog_count == 0, "R1 overprog", 32'(overprog_count), 0);
    verify_all("R1 erased after reset");

    // R3 and R6: program every page of both planes, junk in the low address bits
    for (int p = 0; p < MROWS*4; p++) begin
      fill_page(p + 1);
      do_cmd(3'b010, p*32 + (p*7) % 32, "R6 main page write accepted");
    end
    for (int p = 0; p < DROWS*4; p++) begin
      fill_page(p + 40);
      do_cmd(3'b110, p*32 + (p*11) % 32, "R6 data page write accepted");
    end
    verify_all("R3 sweep programmed");

    // R3 partial write ANDs into existing data
    fill_page(77);
    do_cmd(3'b010, 2*32, "R3 second write");
    verify_all("R3 AND of old and new");

    // R4 erase one row per plane, R5 plane select with offset 0
    do_cmd(3'b001, 128 + 5, "R4 erase main row 1");
    do_cmd(3'b101, 0, "R5 erase data row 0");
    verify_all("R4 erase only the addressed row");

    // R2 pairing rules into erased main page 4
    bus_wr(0, 32'h0, 1);            // pending lower, slot 0
    bus_wr(3, 32'h0, 1);            // upper of slot 1: dropped
    bus_wr(6, 32'h1234_0000, 1);    // pending slot 3
    bus_wr(7, 32'h0000_5678, 1);    // commits slot 3
    bus_wr(8, 32'h0, 1);            // pending slot 4
    bus_wr(10, 32'h0F0F_0F0F, 1);   // replaces pending with slot 5
    bus_wr(9, 32'h0, 1);            // slot 4 upper: dropped
    bus_wr(11, 32'hF0F0_0000, 1);   // commits slot 5
    do_cmd(3'b010, 4*32, "R2 pair write");
    verify_all("R2 only matched pairs commit");

    // R10 buffer cleared and pending discarded after page write
    bus_wr(12, 32'h0, 1);
    do_cmd(3'b010, 5*32, "R10 write with pending half");
    bus_wr(13, 32'h0, 1);
    do_cmd(3'b010, 6*32, "R10 write after clear");
    verify_all("R10 buffer back to ones");

    // R5 unknown operation codes
    do_cmd(3'b000, 0, "R5 code 000 rejected");
    do_cmd(3'b011, 0, "R5 code 011 rejected");
    do_cmd(3'b100, 0, "R5 code 100 rejected");
    do_cmd(3'b111, 0, "R5 code 111 rejected");

    // R9 range limits
    do_cmd(3'b001, 512, "R9 main row past end");
    do_cmd(3'b101, 256, "R9 data row past end");
    do_cmd(3'b110, 300, "R9 data write past end");
    do_cmd(3'b101, 255, "R9 last data row accepted");
    verify_all("R9 no change from rejected commands");

    // R8 command during busy, R2 bus write during busy, R12 read during busy
    cmd_valid = 1; cmd_code = 3'b001; cmd_addr = 16'd0;
    @(negedge clk);
    check(cmd_err == 0, "R8 first command accepted", 32'(cmd_err), 0);
    cmd_code = 3'b110; cmd_addr = 16'd0;
    wr_en = 1; wr_idx = 0; wr_data = 32'h0;
    rd_en = 1; rd_plane = 0; rd_idx = 8'd16;
    @(negedge clk);
    cmd_valid = 0; rd_en = 0;
    check(cmd_err == 1, "R8 reject while busy", 32'(cmd_err), 1);
    check(rd_data === exp_m[16], "R12 read during busy sees old data", rd_data, exp_m[16]);
    wr_idx = 1;
    @(negedge clk);
    wr_en = 0;
    for (int w = 0; w < 10 && !ready; w++) @(negedge clk);
    check(ready == 1, "R7 ready after busy", 32'(ready), 1);
    model_apply(0, 1, 0, 0);
    do_cmd(3'b110, 0, "R2 write with ignored busy data");
    verify_all("R8 R2 busy stimulus had no effect");

    // R12 index beyond data plane returns zero
    rd(1, 200, v);
    check(v == 32'h0, "R12 data index beyond plane", v, 0);

    // R11 over-program counting on main row 2
    do_cmd(3'b001, 256, "R11 erase row 2");
    for (int n = 0; n < 10; n++) begin
      bus_wr(0, ~(32'h1 << n), 1);
      bus_wr(1, 32'hFFFF_FFFF, 1);
      do_cmd(3'b010, 256 + (n % 4) * 32, "R11 repeated program");
    end
    do_cmd(3'b001, 256, "R11 erase clears row count");
    do_cmd(3'b010, 256, "R11 program after erase");
    check(overprog_count == 8'd2, "R11 final count", 32'(overprog_count), 2);
    verify_all("R11 storage after repeated programs");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule